// File: doc/BRIEF.md
# Serial Nibble Display Memory Port

This block is a serial slave that sits between a host and a segment display driver. The host talks to it over four wires: an active-low select, a write strobe, a read strobe and a data line. Data leaves the block on a separate output with its own enable, so the pad can be built elsewhere. Each transaction opens with a three-bit mode code. The code picks one of three things: reading display memory, writing or read-modify-writing display memory, or streaming configuration codes to a neighbouring register block.

The display memory holds one four-bit nibble per segment line. Bit j of a nibble is the state of common line j. The whole memory is presented at all times as one flat vector, so a scan driver can use it directly. While select stays low, the address advances by one after every nibble, so a burst fills or reads consecutive segments. In command mode, nine-bit codes follow one another until select rises. Each completed code is passed on as a one-cycle strobe with the code beside it. The block does not decode the commands.

All four inputs are brought into the system clock domain through synchronizer flops. Strobe edges are detected after synchronization, so the host's strobe phases must each last a few system clocks.

Top module: `lcd_nibble_link`

## Requirements
- R1: Select high (sel_n_i = 1) abandons any transfer in progress without touching memory. After select falls again, the first three write-strobe bits are taken as a fresh mode code.
- R2: Mode codes are received first bit first: 1,1,0 selects read; 1,0,1 selects write or read-modify-write; 1,0,0 selects command. Any other code makes the block ignore the rest of the frame: no memory change and no strobe.
- R3: Every input bit is taken from sdin_i on a rising write strobe. After a data-mode code, a six-bit address follows, most significant bit first. A data nibble follows, least significant bit first.
- R4: In a write frame, every further nibble goes to the next address.
- R5: In a read frame, each falling read strobe puts the next bit of the addressed nibble on sdout_o, bit 0 first. After four bits the address advances.
- R6: In a frame with code 1,0,1, a falling read strobe before the first data bit selects read-modify-write. Each address is then read out as four bits on the read strobe and replaced by four bits on the write strobe. The address then advances.
- R7: In command mode, each group of nine write-strobe bits, first bit as the code's MSB, produces a single-cycle cmd_stb_o pulse carrying the code. Groups continue back to back without a new mode code.
- R8: seg_map_o bit 4k+j equals bit j of the nibble at address k.
- R9: Writes to addresses 32 to 63 change nothing, and reads from them return zero. The address counter wraps from 63 to 0.
- R10: sdout_oe_o rises with the first falling read strobe of a read nibble. It falls on the rising read strobe after that nibble's fourth bit, or when select goes high. It is never high outside a read phase.
- R11: After reset, seg_map_o is all zero, sdout_oe_o is low and cmd_stb_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n_i | input | 1 | Active-low frame select |
| wclk_i | input | 1 | Write strobe, bits taken on rising edge |
| rclk_i | input | 1 | Read strobe, bits driven on falling edge |
| sdin_i | input | 1 | Serial data in |
| sdout_o | output | 1 | Serial data out |
| sdout_oe_o | output | 1 | Output enable for sdout_o |
| cmd_stb_o | output | 1 | One-cycle strobe for a completed command code |
| cmd_code_o | output | CMD_W | Completed command code |
| seg_map_o | output | DEPTH*DATA_W | Flat view of display memory |

## Verification
The bench builds the block with its default parameters: a six-bit address, 32 nibbles of four bits and nine-bit commands. Because memory is only half the address space, the bench can write a burst that walks from address 31 into the unbacked range. It can also start a burst at 63 and watch it wrap onto address 0, and read back zeros from above the memory. Those same values let a read-modify-write burst cross a nibble boundary and let two command codes run back to back inside one frame.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  localparam int ID_W = 3;
  localparam logic [ID_W-1:0] ID_READ  = 3'b110;
  localparam logic [ID_W-1:0] ID_WRITE = 3'b101;
  localparam logic [ID_W-1:0] ID_CMD   = 3'b100;

  typedef enum logic [3:0] {
    ST_PREFIX,
    ST_ADDR,
    ST_WSEL,
    ST_WRITE,
    ST_READ,
    ST_RMW_RD,
    ST_RMW_WR,
    ST_CMD,
    ST_DROP
  } frame_state_t;
endpackage

// File: rtl/lsr_sync.sv
module lsr_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/lsr_nibble_store.sv
module lsr_nibble_store #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 4,
  parameter int DEPTH  = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [DATA_W-1:0]       wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [DATA_W-1:0]       rdata,
  output logic [DEPTH*DATA_W-1:0] flat_o
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic w_in_range, r_in_range;

  assign w_in_range = {1'b0, waddr} < LIMIT;
  assign r_in_range = {1'b0, raddr} < LIMIT;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we && w_in_range) begin
      mem[waddr[IDX_W-1:0]] <= wdata;
    end
  end

  assign rdata = r_in_range ? mem[raddr[IDX_W-1:0]] : '0;

  for (genvar k = 0; k < DEPTH; k++) begin : g_flat
    assign flat_o[k*DATA_W +: DATA_W] = mem[k];
  end
endmodule

// File: rtl/lsr_frame_ctl.sv
module lsr_frame_ctl
  import lsr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 4,
  parameter int CMD_W  = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_hi,
  input  logic              wr_rise,
  input  logic              rd_fall,
  input  logic              rd_rise,
  input  logic              din,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] addr,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic [DATA_W-1:0] wdata,
  output logic              dout,
  output logic              doe,
  output logic              cmd_valid,
  output logic [CMD_W-1:0]  cmd_code
);
  localparam int CNT_W = $clog2(CMD_W + 1);
  localparam int NIB_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] ID_LAST   = CNT_W'(ID_W - 1);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] NIB_LAST  = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);

  frame_state_t      state;
  logic [CNT_W-1:0]  cnt;
  logic [CMD_W-1:0]  shreg, nxt_sh;
  logic [DATA_W-1:0] nib, nxt_nib;
  logic [NIB_W-1:0]  nib_idx;
  logic              mode_rd;
  logic              rd_done;

  assign nxt_sh  = {shreg[CMD_W-2:0], din};
  assign nib_idx = cnt[NIB_W-1:0];

  always_comb begin
    nxt_nib          = nib;
    nxt_nib[nib_idx] = din;
  end

  always_ff @(posedge clk) begin
    we        <= 1'b0;
    cmd_valid <= 1'b0;
    if (rst || sel_hi) begin
      state   <= ST_PREFIX;
      cnt     <= '0;
      doe     <= 1'b0;
      dout    <= 1'b0;
      rd_done <= 1'b0;
      mode_rd <= 1'b0;
      if (rst) begin
        shreg    <= '0;
        nib      <= '0;
        addr     <= '0;
        waddr    <= '0;
        wdata    <= '0;
        cmd_code <= '0;
      end
    end else begin
      if (rd_rise && rd_done) begin
        doe     <= 1'b0;
        rd_done <= 1'b0;
      end
      case (state)
        ST_PREFIX: if (wr_rise) begin
          shreg <= nxt_sh;
          if (cnt == ID_LAST) begin
            cnt <= '0;
            case (nxt_sh[ID_W-1:0])
              ID_READ:  begin state <= ST_ADDR; mode_rd <= 1'b1; end
              ID_WRITE: begin state <= ST_ADDR; mode_rd <= 1'b0; end
              ID_CMD:   state <= ST_CMD;
              default:  state <= ST_DROP;
            endcase
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_ADDR: if (wr_rise) begin
          shreg <= nxt_sh;
          if (cnt == ADDR_LAST) begin
            cnt   <= '0;
            addr  <= nxt_sh[ADDR_W-1:0];
            state <= mode_rd ? ST_READ : ST_WSEL;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_WSEL: begin
          if (rd_fall) begin
            dout    <= rd_data[0];
            doe     <= 1'b1;
            rd_done <= 1'b0;
            cnt     <= CNT_W'(1);
            state   <= ST_RMW_RD;
          end else if (wr_rise) begin
            nib   <= nxt_nib;
            cnt   <= CNT_W'(1);
            state <= ST_WRITE;
          end
        end
        ST_WRITE, ST_RMW_WR: if (wr_rise) begin
          nib <= nxt_nib;
          if (state == ST_RMW_WR) begin
            doe     <= 1'b0;
            rd_done <= 1'b0;
          end
          if (cnt == NIB_LAST) begin
            we    <= 1'b1;
            waddr <= addr;
            wdata <= nxt_nib;
            addr  <= addr + ADDR_W'(1);
            cnt   <= '0;
            if (state == ST_RMW_WR) state <= ST_RMW_RD;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_READ, ST_RMW_RD: if (rd_fall) begin
          dout    <= rd_data[nib_idx];
          doe     <= 1'b1;
          rd_done <= 1'b0;
          if (cnt == NIB_LAST) begin
            cnt     <= '0;
            rd_done <= 1'b1;
            if (state == ST_READ) addr  <= addr + ADDR_W'(1);
            else                  state <= ST_RMW_WR;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_CMD: if (wr_rise) begin
          shreg <= nxt_sh;
          if (cnt == CMD_LAST) begin
            cnt       <= '0;
            cmd_valid <= 1'b1;
            cmd_code  <= nxt_sh;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  // R1: raised select returns the decoder to mode-code reception
  a_r1_sel_restarts: assert property (@(posedge clk) disable iff (rst)
    sel_hi |=> (state == ST_PREFIX && cnt == '0));

  // R10: the enable never outlives a raised select
  a_r10_oe_off_on_sel: assert property (@(posedge clk) disable iff (rst)
    sel_hi |=> !doe);

  // R10: enable only while a read half is in progress
  a_r10_oe_in_read: assert property (@(posedge clk) disable iff (rst)
    doe |-> (state == ST_READ || state == ST_RMW_RD || state == ST_RMW_WR));

  // R7: each command code yields one single-cycle strobe
  a_r7_strobe_single: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);

  // R2: a rejected frame produces neither writes nor strobes
  a_r2_drop_silent: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DROP && $past(state) == ST_DROP) |-> (!we && !cmd_valid));

  // R4: the address moves on exactly one step past each committed nibble
  a_r4_addr_step: assert property (@(posedge clk) disable iff (rst)
    we |-> (addr == waddr + ADDR_W'(1)));
endmodule

// File: rtl/lcd_nibble_link.sv
module lcd_nibble_link #(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 4,
  parameter int DEPTH       = 32,
  parameter int CMD_W       = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sel_n_i,
  input  logic                    wclk_i,
  input  logic                    rclk_i,
  input  logic                    sdin_i,
  output logic                    sdout_o,
  output logic                    sdout_oe_o,
  output logic                    cmd_stb_o,
  output logic [CMD_W-1:0]        cmd_code_o,
  output logic [DEPTH*DATA_W-1:0] seg_map_o
);
  localparam int NPIN = 4;
  // pin order: {data, read strobe, write strobe, select}
  localparam logic [NPIN-1:0] PIN_IDLE = 4'b0111;

  logic [NPIN-1:0]   pins_raw, pins_s;
  logic              sel_s, wr_s, rd_s, din_s;
  logic              wr_d, rd_d;
  logic              wr_rise, rd_fall, rd_rise;
  logic [ADDR_W-1:0] addr, waddr;
  logic [DATA_W-1:0] wdata, rd_data;
  logic              we;

  assign pins_raw = {sdin_i, rclk_i, wclk_i, sel_n_i};

  for (genvar g = 0; g < NPIN; g++) begin : g_sync
    lsr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE[g])) u_sync (
      .clk(clk), .rst(rst), .d(pins_raw[g]), .q(pins_s[g]));
  end

  assign {din_s, rd_s, wr_s, sel_s} = pins_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_d <= 1'b1;
      rd_d <= 1'b1;
    end else begin
      wr_d <= wr_s;
      rd_d <= rd_s;
    end
  end

  assign wr_rise = wr_s & ~wr_d;
  assign rd_fall = ~rd_s & rd_d;
  assign rd_rise = rd_s & ~rd_d;

  lsr_frame_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_W(CMD_W)) u_ctl (
    .clk(clk), .rst(rst), .sel_hi(sel_s), .wr_rise(wr_rise),
    .rd_fall(rd_fall), .rd_rise(rd_rise), .din(din_s), .rd_data(rd_data),
    .addr(addr), .we(we), .waddr(waddr), .wdata(wdata),
    .dout(sdout_o), .doe(sdout_oe_o),
    .cmd_valid(cmd_stb_o), .cmd_code(cmd_code_o));

  lsr_nibble_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(addr), .rdata(rd_data), .flat_o(seg_map_o));

  // R9: a write aimed past the backed range leaves the segment view unchanged
  a_r9_high_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (we && ({1'b0, waddr} >= (ADDR_W+1)'(DEPTH))) |=> $stable(seg_map_o));
endmodule

// File: tb/tb_lcd_nibble_link.sv
module tb_lcd_nibble_link;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_n = 1'b1, wclk = 1'b1, rclk = 1'b1, sdin = 1'b0;
  logic sdout, sdout_oe, cmd_stb;
  logic [8:0]   cmd_code;
  logic [127:0] seg_map;

  int checks = 0, errors = 0;
  int cmd_count = 0;
  logic [8:0] cmd_seen [8];

  always #2 clk = ~clk;

  lcd_nibble_link dut (
    .clk(clk), .rst(rst), .sel_n_i(sel_n), .wclk_i(wclk), .rclk_i(rclk),
    .sdin_i(sdin), .sdout_o(sdout), .sdout_oe_o(sdout_oe),
    .cmd_stb_o(cmd_stb), .cmd_code_o(cmd_code), .seg_map_o(seg_map));

  always @(negedge clk) begin
    if (cmd_stb) begin
      if (cmd_count < 8) cmd_seen[cmd_count] = cmd_code;
      cmd_count = cmd_count + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int nib_at(input int k);
    return int'(seg_map[k*4 +: 4]);
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic open_frame();
    sel_n = 1'b1; wait_n(8);
    sel_n = 1'b0; wait_n(8);
  endtask

  task automatic close_frame();
    sel_n = 1'b1; wait_n(10);
  endtask

  task automatic wbit(input logic b);
    sdin = b; wait_n(4);
    wclk = 1'b0; wait_n(4);
    wclk = 1'b1; wait_n(4);
  endtask

  task automatic send_msb(input int val, input int n);
    for (int i = n - 1; i >= 0; i--) wbit(val[i]);
  endtask

  task automatic send_nib(input int val);
    for (int i = 0; i < 4; i++) wbit(val[i]);
  endtask

  task automatic read_nib(output int val, output int oe_all);
    val = 0; oe_all = 1;
    for (int i = 0; i < 4; i++) begin
      rclk = 1'b0; wait_n(6);
      val[i] = sdout;
      if (!sdout_oe) oe_all = 0;
      rclk = 1'b1; wait_n(6);
    end
  endtask

  task automatic t_reset();
    chk("R11 map zero", int'(seg_map != '0), 0);
    chk("R11 oe low", int'(sdout_oe), 0);
    chk("R11 no strobe", cmd_count, 0);
  endtask

  task automatic t_write_single();
    open_frame(); send_msb(3'b101, 3); send_msb(3, 6); send_nib(4'hA); close_frame();
    chk("R3 nibble at 3", nib_at(3), 4'hA);
    chk("R8 bit 12 (COM0 of addr 3)", int'(seg_map[12]), 0);
    chk("R8 bit 13 (COM1 of addr 3)", int'(seg_map[13]), 1);
  endtask

  task automatic t_write_burst();
    open_frame(); send_msb(3'b101, 3); send_msb(10, 6);
    send_nib(1); send_nib(2); send_nib(3); close_frame();
    chk("R4 addr 10", nib_at(10), 1);
    chk("R4 addr 11", nib_at(11), 2);
    chk("R4 addr 12", nib_at(12), 3);
  endtask

  task automatic t_high_wrap();
    open_frame(); send_msb(3'b101, 3); send_msb(31, 6);
    send_nib(5); send_nib(7); send_nib(9); close_frame();
    chk("R9 addr 31 written", nib_at(31), 5);
    chk("R9 addr 0 untouched by high writes", nib_at(0), 0);
    open_frame(); send_msb(3'b101, 3); send_msb(63, 6);
    send_nib(4'hC); send_nib(4'hD); close_frame();
    chk("R9 wrap to addr 0", nib_at(0), 4'hD);
    chk("R9 addr 1 untouched", nib_at(1), 0);
  endtask

  task automatic t_read();
    int v, oe;
    open_frame(); send_msb(3'b110, 3); send_msb(10, 6);
    chk("R10 oe low before read strobe", int'(sdout_oe), 0);
    read_nib(v, oe); chk("R5 read addr 10", v, 1); chk("R10 oe during nibble", oe, 1);
    wait_n(4);
    chk("R10 oe low after nibble", int'(sdout_oe), 0);
    read_nib(v, oe); chk("R5 read addr 11", v, 2);
    read_nib(v, oe); chk("R5 read addr 12", v, 3);
    close_frame();
    open_frame(); send_msb(3'b110, 3); send_msb(40, 6);
    read_nib(v, oe); chk("R9 read above memory", v, 0);
    rclk = 1'b0; wait_n(6);
    chk("R10 oe high mid nibble", int'(sdout_oe), 1);
    sel_n = 1'b1; wait_n(6);
    chk("R10 oe dropped by select", int'(sdout_oe), 0);
    rclk = 1'b1; close_frame();
  endtask

  task automatic t_rmw();
    int v, oe;
    open_frame(); send_msb(3'b101, 3); send_msb(11, 6);
    read_nib(v, oe); chk("R6 rmw read addr 11", v, 2);
    send_nib(4'hE);
    read_nib(v, oe); chk("R6 rmw read addr 12", v, 3);
    send_nib(4'hF);
    close_frame();
    chk("R6 rmw wrote addr 11", nib_at(11), 4'hE);
    chk("R6 rmw wrote addr 12", nib_at(12), 4'hF);
    chk("R6 addr 13 untouched", nib_at(13), 0);
  endtask

  task automatic t_cmd();
    int base;
    base = cmd_count;
    open_frame(); send_msb(3'b100, 3);
    send_msb(9'h1A5, 9); send_msb(9'h003, 9); close_frame();
    chk("R7 two strobes", cmd_count - base, 2);
    chk("R7 first code", int'(cmd_seen[base]), 9'h1A5);
    chk("R7 second code", int'(cmd_seen[base + 1]), 9'h003);
  endtask

  task automatic t_abort();
    int v, oe;
    open_frame(); send_msb(3'b101, 3); send_msb(3, 6);
    wbit(1'b1); wbit(1'b1);
    close_frame();
    chk("R1 aborted nibble leaves addr 3", nib_at(3), 4'hA);
    open_frame(); send_msb(3'b110, 3); send_msb(3, 6);
    read_nib(v, oe); close_frame();
    chk("R1 fresh code after abort", v, 4'hA);
  endtask

  task automatic t_bad_id();
    int base;
    base = cmd_count;
    open_frame(); send_msb(3'b111, 3); send_msb(20, 6); send_nib(4'hF); close_frame();
    chk("R2 code 111 ignored", nib_at(20), 0);
    open_frame(); send_msb(3'b011, 3); send_msb(9'h1FF, 9); close_frame();
    chk("R2 code 011 no strobe", cmd_count - base, 0);
    chk("R2 map unchanged", nib_at(20) | nib_at(21) | nib_at(22), 0);
  endtask

  logic done = 1'b0;

  initial begin
    wait_n(5);
    rst = 1'b0;
    wait_n(5);
    t_reset();
    t_write_single();
    t_write_burst();
    t_high_wrap();
    t_read();
    t_rmw();
    t_cmd();
    t_abort();
    t_bad_id();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule